// File: doc/BRIEF.md
# Register Push/Pull Stack Unit

This block carries out the one-byte stack instructions of a small 8-bit processor core: pushing and pulling the accumulator, pushing and pulling the status byte, and moving values between index X and the stack pointer. It holds the 8-bit stack pointer, the accumulator, index X and a status byte whose N and Z bits it updates. Stack traffic always goes to a fixed page, so the 16-bit bus address during a stack access is the page number in the high byte and the pointer in the low byte.

The fetch unit sends a single-cycle start pulse together with an operation code in the cycle that follows the opcode fetch, and it supplies the address of the next program byte on `pc`. In that first cycle the unit reads `pc` and discards the byte. A push then writes at the current pointer and decrements it. A pull first spends a cycle on a dummy stack read while it increments the pointer, then reads the byte at the new pointer. `done` marks the last bus cycle of each operation, and register results appear one clock later.

Top module: `stk_unit`

## Requirements
- R1: After reset the stack pointer is 0xFF, the accumulator, index X and status are 0x00, `done` and `we` are low, and `addr` follows `pc`.
- R2: Operation code 0 (push accumulator) takes 2 cycles from start: a read at `pc`, then a write of the accumulator at address 0x0100 plus the pointer with `done` high; the pointer then drops by one.
- R3: Operation code 1 (pull accumulator) takes 3 cycles: a read at `pc`, a dummy read at 0x0100 plus the pointer after which the pointer rises by one, then a read at 0x0100 plus the new pointer with `done` high whose byte is loaded into the accumulator.
- R4: A pull of the accumulator sets status bit 7 (N) to bit 7 of the pulled byte and status bit 1 (Z) when the byte is zero; the other six status bits keep their value.
- R5: Operation code 2 (push status) takes 2 cycles like R2 but writes the status byte, and leaves status, accumulator and index X unchanged.
- R6: Operation code 3 (pull status) takes 3 cycles like R3 and replaces all eight status bits with the pulled byte, leaving accumulator and index X unchanged.
- R7: Operation code 4 (X to pointer) completes in 1 cycle with `done` high during the read at `pc`; the pointer becomes X and status is unchanged.
- R8: Operation code 5 (pointer to X) completes in 1 cycle; X becomes the pointer, status bit 7 takes bit 7 of the pointer, status bit 1 is set when the pointer is zero, and the other status bits are unchanged.
- R9: The pointer wraps modulo 256: a push at 0x00 writes 0x0100 and leaves 0xFF, and a pull at 0xFF performs its dummy read at 0x01FF and its data read at 0x0100, leaving 0x00.
- R10: A start pulse that arrives while an operation is in progress is ignored: no extra bus write and no extra pointer change.
- R11: Operation codes 6 and 7 complete in 1 cycle with `done` high and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the operation given on `op` (cycle after opcode fetch) |
| op | input | 3 | Operation code, see R2 to R11 |
| pc | input | 16 | Address of the byte after the opcode |
| addr | output | 16 | Bus address |
| we | output | 1 | High for a bus write, low for a read |
| wdata | output | 8 | Write data |
| rdata | input | 8 | Read data, valid in the same cycle as `addr` |
| done | output | 1 | High in the final bus cycle of an operation |
| acc | output | 8 | Accumulator |
| idx_x | output | 8 | Index X |
| status | output | 8 | Status byte, N at bit 7, Z at bit 1 |
| sp | output | 8 | Stack pointer |

## Verification
Bus results are due inside the operation: the bench samples `addr`, `we`, `wdata` and `done` a quarter period after the falling edge in every cycle from the start cycle onward, so the start cycle, the stack cycle and the pull data cycle are each checked at their own cycle index. Register results are due one clock after the cycle in which `done` is high, so the bench reads the accumulator, X, status and pointer at the falling edge after that rising edge. The operation length is counted from start to `done` and compared with 1, 2 or 3 cycles per operation code.

// File: rtl/stk_pkg.sv
package stk_pkg;
   localparam logic [2:0] OP_PUSH_A  = 3'd0;
   localparam logic [2:0] OP_PULL_A  = 3'd1;
   localparam logic [2:0] OP_PUSH_P  = 3'd2;
   localparam logic [2:0] OP_PULL_P  = 3'd3;
   localparam logic [2:0] OP_X_TO_SP = 3'd4;
   localparam logic [2:0] OP_SP_TO_X = 3'd5;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_STACK = 2'd1,
      PH_PULL  = 2'd2
   } phase_t;

   function automatic logic is_push(input logic [2:0] o);
      return (o == OP_PUSH_A) || (o == OP_PUSH_P);
   endfunction

   function automatic logic is_pull(input logic [2:0] o);
      return (o == OP_PULL_A) || (o == OP_PULL_P);
   endfunction
endpackage

// File: rtl/stk_seq.sv
module stk_seq
   import stk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [2:0] op,
   output logic       stack_sel,
   output logic       wr_en,
   output logic       sp_inc,
   output logic       sp_dec,
   output logic       ld_sp_x,
   output logic       ld_x_sp,
   output logic       ld_a_mem,
   output logic       ld_p_mem,
   output logic       push_p,
   output logic       done
);
   phase_t     phase_q, phase_d;
   logic [2:0] op_q;
   logic       accept;

   assign accept = (phase_q == PH_IDLE) && start;
   assign push_p = (op_q == OP_PUSH_P);

   always_comb begin
      phase_d   = phase_q;
      stack_sel = 1'b0;
      wr_en     = 1'b0;
      sp_inc    = 1'b0;
      sp_dec    = 1'b0;
      ld_sp_x   = 1'b0;
      ld_x_sp   = 1'b0;
      ld_a_mem  = 1'b0;
      ld_p_mem  = 1'b0;
      done      = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (accept) begin
               if (is_push(op) || is_pull(op)) begin
                  phase_d = PH_STACK;
               end else begin
                  done    = 1'b1;
                  ld_sp_x = (op == OP_X_TO_SP);
                  ld_x_sp = (op == OP_SP_TO_X);
               end
            end
         end
         PH_STACK: begin
            stack_sel = 1'b1;
            if (is_push(op_q)) begin
               wr_en   = 1'b1;
               sp_dec  = 1'b1;
               done    = 1'b1;
               phase_d = PH_IDLE;
            end else begin
               sp_inc  = 1'b1;
               phase_d = PH_PULL;
            end
         end
         PH_PULL: begin
            stack_sel = 1'b1;
            done      = 1'b1;
            ld_a_mem  = (op_q == OP_PULL_A);
            ld_p_mem  = (op_q == OP_PULL_P);
            phase_d   = PH_IDLE;
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         op_q    <= 3'd0;
      end else begin
         phase_q <= phase_d;
         if (accept) op_q <= op;
      end
   end

   // R2: one write per push
   p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);
   // R10: the cycle after done never carries a stack access of the old operation
   p_done_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !(wr_en || sp_inc || ld_a_mem || ld_p_mem));
   // R3: the dummy stack read is followed by the data read
   p_pull_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sp_inc |=> (ld_a_mem || ld_p_mem) && done);
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
   parameter int            DATA_W  = 8,
   parameter logic [DATA_W-1:0] SP_INIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              dec,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   output logic [DATA_W-1:0] sp
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sp <= SP_INIT;
      else if (load) sp <= load_val;
      else if (inc)  sp <= sp + ONE;
      else if (dec)  sp <= sp - ONE;
   end

   // R2, R9: decrement wraps modulo 2^DATA_W
   p_dec_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && !inc) |=> sp == DATA_W'($past(sp) - ONE));
   // R3, R9: increment wraps modulo 2^DATA_W
   p_inc_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load) |=> sp == DATA_W'($past(sp) + ONE));
   // R7
   p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> sp == $past(load_val));
   // R11
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc || dec || load) |=> $stable(sp));
endmodule

// File: rtl/stk_regs.sv
module stk_regs #(
   parameter int DATA_W = 8,
   parameter int N_POS  = 7,
   parameter int Z_POS  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_a_mem,
   input  logic              ld_p_mem,
   input  logic              ld_x_sp,
   input  logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] sp,
   output logic [DATA_W-1:0] acc,
   output logic [DATA_W-1:0] idx_x,
   output logic [DATA_W-1:0] status
);
   localparam int MSB = DATA_W - 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         idx_x  <= '0;
         status <= '0;
      end else begin
         if (ld_a_mem) begin
            acc           <= rdata;
            status[N_POS] <= rdata[MSB];
            status[Z_POS] <= (rdata == '0);
         end
         if (ld_p_mem) status <= rdata;
         if (ld_x_sp) begin
            idx_x         <= sp;
            status[N_POS] <= sp[MSB];
            status[Z_POS] <= (sp == '0);
         end
      end
   end

   // R4: flags agree with the loaded accumulator
   p_pull_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ld_a_mem |=> (status[N_POS] == acc[MSB]) && (status[Z_POS] == (acc == '0)));
   // R8: flags agree with the transferred index
   p_xfer_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_x_sp |=> (status[N_POS] == idx_x[MSB]) && (status[Z_POS] == (idx_x == '0)));
   // R5, R7, R11: status untouched without a load
   p_status_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_a_mem || ld_p_mem || ld_x_sp) |=> $stable(status));
   // R6
   p_acc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_a_mem |=> $stable(acc));
endmodule

// File: rtl/stk_unit.sv
module stk_unit
   import stk_pkg::*;
#(
   parameter int   ADDR_W     = 16,
   parameter int   DATA_W     = 8,
   parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 'h01,
   parameter logic [DATA_W-1:0]        SP_INIT    = '1,
   parameter int   N_POS      = 7,
   parameter int   Z_POS      = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op,
   input  logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] addr,
   output logic              we,
   output logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] rdata,
   output logic              done,
   output logic [DATA_W-1:0] acc,
   output logic [DATA_W-1:0] idx_x,
   output logic [DATA_W-1:0] status,
   output logic [DATA_W-1:0] sp
);
   localparam int PAGE_W = ADDR_W - DATA_W;

   generate
      if (PAGE_W < 1) begin : g_bad_addr
         $error("stk_unit: ADDR_W must exceed DATA_W");
      end
      if (N_POS >= DATA_W || Z_POS >= DATA_W || N_POS == Z_POS) begin : g_bad_flags
         $error("stk_unit: flag positions out of range or equal");
      end
   endgenerate

   logic stack_sel, sp_inc, sp_dec, ld_sp_x, ld_x_sp, ld_a_mem, ld_p_mem, push_p;

   stk_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .op       (op),
      .stack_sel(stack_sel),
      .wr_en    (we),
      .sp_inc   (sp_inc),
      .sp_dec   (sp_dec),
      .ld_sp_x  (ld_sp_x),
      .ld_x_sp  (ld_x_sp),
      .ld_a_mem (ld_a_mem),
      .ld_p_mem (ld_p_mem),
      .push_p   (push_p),
      .done     (done)
   );

   stk_ptr #(.DATA_W(DATA_W), .SP_INIT(SP_INIT)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (sp_inc),
      .dec     (sp_dec),
      .load    (ld_sp_x),
      .load_val(idx_x),
      .sp      (sp)
   );

   stk_regs #(.DATA_W(DATA_W), .N_POS(N_POS), .Z_POS(Z_POS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_a_mem(ld_a_mem),
      .ld_p_mem(ld_p_mem),
      .ld_x_sp (ld_x_sp),
      .rdata   (rdata),
      .sp      (sp),
      .acc     (acc),
      .idx_x   (idx_x),
      .status  (status)
   );

   assign addr  = stack_sel ? {STACK_PAGE, sp} : pc;
   assign wdata = push_p ? status : acc;

   // R2: a write lands where the pointer was, which then drops by one
   p_write_then_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> sp == DATA_W'($past(addr[DATA_W-1:0]) - DATA_W'(1)));
   // R3: pulled byte reaches the accumulator
   p_pull_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ld_a_mem |=> acc == $past(rdata));
   // R6: pulled byte reaches status whole
   p_pull_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ld_p_mem |=> status == $past(rdata));
   // R9: stack accesses stay in the stack page
   p_stack_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> addr[ADDR_W-1:DATA_W] == STACK_PAGE);
endmodule

// File: tb/tb_stk_unit.sv
`timescale 1ns/1ps
module tb_stk_unit;
   localparam logic [15:0] PC = 16'h0201;

   typedef struct packed {
      logic [2:0]  op;
      logic [1:0]  cyc;
      logic        wr;
      logic [15:0] waddr;
      logic [7:0]  wdata;
      logic [7:0]  a;
      logic [7:0]  x;
      logic [7:0]  p;
      logic [7:0]  sp;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{3'd1, 2'd3, 1'b0, 16'h0000, 8'h00, 8'h80, 8'h00, 8'h80, 8'h00},
      '{3'd1, 2'd3, 1'b0, 16'h0000, 8'h00, 8'h00, 8'h00, 8'h02, 8'h01},
      '{3'd3, 2'd3, 1'b0, 16'h0000, 8'h00, 8'h00, 8'h00, 8'h5D, 8'h02},
      '{3'd2, 2'd2, 1'b1, 16'h0102, 8'h5D, 8'h00, 8'h00, 8'h5D, 8'h01},
      '{3'd5, 2'd1, 1'b0, 16'h0000, 8'h00, 8'h00, 8'h01, 8'h5D, 8'h01},
      '{3'd1, 2'd3, 1'b0, 16'h0000, 8'h00, 8'h5D, 8'h01, 8'h5D, 8'h02},
      '{3'd0, 2'd2, 1'b1, 16'h0102, 8'h5D, 8'h5D, 8'h01, 8'h5D, 8'h01},
      '{3'd0, 2'd2, 1'b1, 16'h0101, 8'h5D, 8'h5D, 8'h01, 8'h5D, 8'h00},
      '{3'd5, 2'd1, 1'b0, 16'h0000, 8'h00, 8'h5D, 8'h00, 8'h5F, 8'h00},
      '{3'd0, 2'd2, 1'b1, 16'h0100, 8'h5D, 8'h5D, 8'h00, 8'h5F, 8'hFF},
      '{3'd4, 2'd1, 1'b0, 16'h0000, 8'h00, 8'h5D, 8'h00, 8'h5F, 8'h00},
      '{3'd7, 2'd1, 1'b0, 16'h0000, 8'h00, 8'h5D, 8'h00, 8'h5F, 8'h00},
      '{3'd2, 2'd2, 1'b1, 16'h0100, 8'h5F, 8'h5D, 8'h00, 8'h5F, 8'hFF},
      '{3'd1, 2'd3, 1'b0, 16'h0000, 8'h00, 8'h5F, 8'h00, 8'h5D, 8'h00}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [15:0] addr;
   logic        we, done;
   logic [7:0]  wdata, rdata, acc, idx_x, status, sp;
   logic [7:0]  mem [512];

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   stk_unit dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pc(PC),
      .addr(addr), .we(we), .wdata(wdata), .rdata(rdata), .done(done),
      .acc(acc), .idx_x(idx_x), .status(status), .sp(sp)
   );

   assign rdata = mem[addr[8:0]];
   always @(posedge clk) if (we) mem[addr[8:0]] <= wdata;

   task automatic chk(input logic ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input logic [2:0] o);
      case (o)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd4: return "R7";
         3'd5: return "R8";
         default: return "R11";
      endcase
   endfunction

   initial begin : watchdog
      #200000;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 512; i++) mem[i] = 8'h00;
      mem[9'h100] = 8'h80;
      mem[9'h101] = 8'h00;
      mem[9'h102] = 8'h5D;

      repeat (3) @(negedge clk);
      #5;
      // R1 reset state
      chk(sp == 8'hFF, "R1", "sp", sp, 8'hFF);
      chk(acc == 8'h00 && idx_x == 8'h00 && status == 8'h00, "R1", "acc/x/p",
          {acc, idx_x, status}, 0);
      chk(!done && !we, "R1", "done/we", {done, we}, 0);
      chk(addr == PC, "R1", "addr", addr, PC);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         string      rq;
         logic [7:0] sp0;
         int         k;
         int         nwr;
         logic       seen_done;
         rq  = req_of(VEC[i].op);
         sp0 = sp;
         k   = 0;
         nwr = 0;
         seen_done = 1'b0;
         op    = VEC[i].op;
         start = 1'b1;
         while (!seen_done && k < 6) begin
            #5;
            if (k == 0) begin
               chk(addr == PC && !we, rq, "start-cycle addr", addr, PC);
            end else if (k == 1) begin
               chk(addr == {8'h01, sp0}, rq, "stack addr", addr, {8'h01, sp0});
            end else if (k == 2) begin
               chk(addr == {8'h01, 8'(sp0 + 8'd1)}, rq, "pull data addr", addr,
                   {8'h01, 8'(sp0 + 8'd1)});
            end
            if (we) begin
               nwr++;
               chk(addr == VEC[i].waddr && wdata == VEC[i].wdata, rq, "write",
                   {addr, wdata}, {VEC[i].waddr, VEC[i].wdata});
            end
            seen_done = done;
            k++;
            @(negedge clk);
            start = 1'b0;
         end
         chk(k == int'(VEC[i].cyc), rq, "cycles", k, VEC[i].cyc);
         chk(nwr == int'(VEC[i].wr), rq, "write count", nwr, VEC[i].wr);
         chk(acc == VEC[i].a, rq, "acc", acc, VEC[i].a);
         chk(idx_x == VEC[i].x, rq, "idx_x", idx_x, VEC[i].x);
         chk(status == VEC[i].p, (VEC[i].op == 3'd1) ? "R4" : rq, "status",
             status, VEC[i].p);
         chk(sp == VEC[i].sp, rq, "sp", sp, VEC[i].sp);
         if (i == 0 || i == 9 || i == 12 || i == 13)
            chk(sp == VEC[i].sp, "R9", "wrapped sp", sp, VEC[i].sp);
      end

      // R10: start held high during the stack cycle of a push at sp=00
      begin
         int nwr;
         nwr = 0;
         op    = 3'd0;
         start = 1'b1;
         for (int k = 0; k < 4; k++) begin
            #5;
            if (we) nwr++;
            @(negedge clk);
            if (k == 1) start = 1'b0;
         end
         chk(nwr == 1, "R10", "writes with start held", nwr, 1);
         chk(sp == 8'hFF, "R10", "sp after held start", sp, 8'hFF);
         chk(mem[9'h100] == 8'h5F, "R10", "pushed byte", mem[9'h100], 8'h5F);
         chk(acc == 8'h5F && status == 8'h5D, "R10", "acc/status",
             {acc, status}, 16'h5F5D);
      end

      // R11: code 6 has no effect
      begin
         int k;
         k = 0;
         op    = 3'd6;
         start = 1'b1;
         #5;
         chk(done && !we, "R11", "code 6 done", {done, we}, 2'b10);
         @(negedge clk);
         start = 1'b0;
         #5;
         chk(!done, "R11", "code 6 single cycle", done, 0);
         chk(sp == 8'hFF && acc == 8'h5F && idx_x == 8'h00 && status == 8'h5D,
             "R11", "regs after code 6", {sp, acc, idx_x, status}, 32'hFF5F005D);
         @(negedge clk);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule